// File: doc/BRIEF.md
# Receive Sync Pulse Generator with Programmable Phase and Word Capture

This block drives the receive-side sync pulse of a sampling front end. It runs on a clock at 48 times the symbol rate and watches a symbol-clock reference. Once per symbol it raises a sync pulse whose position within the symbol is set by a 6-bit delay in steps of 1/48 of a symbol. Delay 0 puts the pulse at the symbol-clock falling edge. The sync pulse also decides which converter samples are taken. The converter produces two words per symbol, half a symbol apart. The block takes the word that is present when the sync pulse starts. In one of its two modes it also takes the word half a symbol later.

Captured words leave on a single stream with a one-cycle valid strobe. A tag bit tells the first word of a symbol from the second. The delay setting can be rewritten at any time, but it takes effect only at the next symbol boundary. When a change of delay would make two sync pulses touch or merge, the later pulse is dropped, so every pulse that does appear has the nominal width.

Top module: `rx_sync_capture`

## Requirements
- R1: While reset is asserted and after it is released, sync_o and word_valid are 0, word_data is all zeros and word_phase is 0.
- R2: No sync pulse and no word appear until a falling edge of sym_clk has been seen, meaning a cycle where sym_clk is sampled 0 after being sampled 1. That cycle is phase 0.
- R3: With an effective delay d, the sync start falls in the clock cycle at phase d. sync_o is 1 from the edge that ends that cycle. This means sync_o first reads 1 d cycles after the cycle in which the falling edge was sampled.
- R4: Each sync pulse is high for exactly two clock cycles, at most one pulse starts per symbol, and it is followed by at least one low cycle. A start that falls while the previous pulse, or the cycle after that pulse, is still pending is dropped.
- R5: A dly_set value of 48 or more behaves as 47.
- R6: dly_set is sampled only in the phase 0 cycle. A change made within a symbol does not move that symbol's pulse.
- R7: In the cycle of each sync start, adc_word is captured. word_valid is 1 for the next cycle only, with word_data equal to the captured word and word_phase 0.
- R8: fwd_mode is sampled at the sync start. When it is 1, adc_word is captured again 24 cycles after the start and presented for one cycle with word_phase 1. When it is 0, no second word is produced.
- R9: A sync start cancels any second word still pending from the previous start, including one due in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 48 times the symbol rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_clk | input | 1 | Symbol-clock reference, synchronous to clk, one period per 48 clk cycles |
| dly_set | input | 6 | Sync delay in 1/48 symbol steps (values above 47 clamp to 47) |
| fwd_mode | input | 1 | 0: forward the first word only; 1: forward both words |
| adc_word | input | 14 | Converter output word |
| sync_o | output | 1 | Receive sync pulse, two cycles wide |
| word_valid | output | 1 | One-cycle strobe for word_data |
| word_data | output | 14 | Captured converter word |
| word_phase | output | 1 | 0 for the word taken at the sync start, 1 for the word taken half a symbol later |

## Verification
The hardest states to reach are the ones where a delay change lands across a symbol boundary. Moving from delay 47 to delay 0 puts two starts one cycle apart, which must drop a pulse. Moving from a late delay in both-words mode to an early one lets a new start overtake the pending second word. The stimulus reaches these states with directed symbol sequences: 47 followed by 0, 40 followed by 5, and a mid-symbol rewrite. It then runs many symbols with random delays of up to 63, random modes and random rewrite points. A cycle-accurate reference built from the requirements follows all of this.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic {
    FWD_FIRST = 1'b0,
    FWD_BOTH  = 1'b1
  } fwd_mode_e;

endpackage

// File: rtl/rxs_phase_gen.sv
module rxs_phase_gen #(
  parameter  int unsigned PERIOD = 48,
  localparam int unsigned DLY_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_clk,
  input  logic [DLY_W-1:0] dly_set,
  output logic             start_raw,
  output logic             locked_o,
  output logic [DLY_W-1:0] dly_act_o
);

  localparam logic [DLY_W-1:0] LAST = DLY_W'(PERIOD - 1);

  logic             sym_q;
  logic [DLY_W-1:0] ph_q, ph_d;
  logic [DLY_W-1:0] dact_q, dclamp, dly_now;
  logic             locked_q, locked_d;
  logic             fall;

  // phase 0 is the cycle in which the falling edge is first sampled
  always_comb begin
    fall      = sym_q & ~sym_clk;
    ph_d      = fall ? '0 : ((ph_q == LAST) ? '0 : ph_q + 1'b1);
    dclamp    = (dly_set > LAST) ? LAST : dly_set;
    dly_now   = fall ? dclamp : dact_q;
    locked_d  = locked_q | fall;
    start_raw = locked_d & (ph_d == dly_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q    <= 1'b0;
      ph_q     <= '0;
      locked_q <= 1'b0;
    end else begin
      sym_q    <= sym_clk;
      ph_q     <= ph_d;
      locked_q <= locked_d;
    end
  end

  // delay setting is only taken at a symbol boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dact_q <= '0;
    end else if (fall) begin
      dact_q <= dclamp;
    end
  end

  assign locked_o  = locked_q;
  assign dly_act_o = dact_q;

endmodule

// File: rtl/rxs_pulse.sv
module rxs_pulse #(
  parameter  int unsigned PULSE_W = 2,
  localparam int unsigned CNT_W   = (PULSE_W > 2) ? $clog2(PULSE_W) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic sync_o,
  output logic busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q, sync_d;

  always_comb begin
    if (start) begin
      cnt_d = CNT_W'(PULSE_W - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    sync_d = start | (cnt_q != '0);
    busy   = sync_q | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/rxs_capture.sv
module rxs_capture
  import rxs_pkg::*;
#(
  parameter  int unsigned PERIOD = 48,
  parameter  int unsigned DW     = 14,
  localparam int unsigned HALF   = PERIOD / 2,
  localparam int unsigned HC_W   = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  fwd_mode_e     mode,
  input  logic [DW-1:0] data_in,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          phase_o
);

  localparam logic [HC_W-1:0] HALF_V = HC_W'(HALF);
  localparam logic [HC_W-1:0] ONE_V  = HC_W'(1);

  logic [HC_W-1:0] hc_q, hc_d;
  fwd_mode_e       mode_q;
  logic            second, load;
  logic            valid_q;
  logic [DW-1:0]   data_q;
  logic            phase_q;

  // a new start reloads the half-symbol timer and so drops a pending word
  always_comb begin
    if (start) begin
      hc_d = HALF_V;
    end else if (hc_q != '0) begin
      hc_d = hc_q - 1'b1;
    end else begin
      hc_d = hc_q;
    end
    second = ~start & (hc_q == ONE_V) & (mode_q == FWD_BOTH);
    load   = start | second;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      hc_q    <= hc_d;
      valid_q <= load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FWD_FIRST;
    end else if (start) begin
      mode_q <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      phase_q <= 1'b0;
    end else if (load) begin
      data_q  <= data_in;
      phase_q <= second;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/rx_sync_capture.sv
module rx_sync_capture
  import rxs_pkg::*;
#(
  parameter  int unsigned PERIOD  = 48,
  parameter  int unsigned DW      = 14,
  parameter  int unsigned PULSE_W = 2,
  localparam int unsigned DLY_W   = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_clk,
  input  logic [DLY_W-1:0] dly_set,
  input  logic             fwd_mode,
  input  logic [DW-1:0]    adc_word,
  output logic             sync_o,
  output logic             word_valid,
  output logic [DW-1:0]    word_data,
  output logic             word_phase
);

  logic             start_raw, start, busy, locked;
  logic [DLY_W-1:0] dly_act;

  rxs_phase_gen #(.PERIOD(PERIOD)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_clk   (sym_clk),
    .dly_set   (dly_set),
    .start_raw (start_raw),
    .locked_o  (locked),
    .dly_act_o (dly_act)
  );

  // a start inside a pulse or its trailing low cycle is dropped
  assign start = start_raw & ~busy;

  rxs_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .sync_o (sync_o),
    .busy   (busy)
  );

  rxs_capture #(.PERIOD(PERIOD), .DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (fwd_mode_e'(fwd_mode)),
    .data_in (adc_word),
    .valid_o (word_valid),
    .data_o  (word_data),
    .phase_o (word_phase)
  );

endmodule

// File: rtl/rxs_sva.sv
module rxs_sva #(
  parameter  int unsigned PERIOD = 48,
  localparam int unsigned DLY_W  = $clog2(PERIOD)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_o,
  input logic             word_valid,
  input logic             word_phase,
  input logic             locked,
  input logic [DLY_W-1:0] dly_act
);

  a_r2_lock_first: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> locked);

  a_r4_two_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |=> sync_o);

  a_r4_then_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && $past(sync_o)) |=> !sync_o);

  a_r5_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    dly_act <= DLY_W'(PERIOD - 1));

  a_r7_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> (word_valid && !word_phase));

  a_r8_tag_zero_only_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_phase) |-> $rose(sync_o));

endmodule

bind rx_sync_capture rxs_sva #(.PERIOD(PERIOD)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_o     (sync_o),
  .word_valid (word_valid),
  .word_phase (word_phase),
  .locked     (locked),
  .dly_act    (dly_act)
);

// File: tb/rx_sync_capture_tb.sv
module rx_sync_capture_tb_top;

  localparam int PERIOD = 48;
  localparam int DW     = 14;

  logic          clk;
  logic          rst_n;
  logic          sym_clk;
  logic [5:0]    dly_set;
  logic          fwd_mode;
  logic [DW-1:0] adc_word;
  logic          sync_o, word_valid, word_phase;
  logic [DW-1:0] word_data;

  rx_sync_capture dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_clk    (sym_clk),
    .dly_set    (dly_set),
    .fwd_mode   (fwd_mode),
    .adc_word   (adc_word),
    .sync_o     (sync_o),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_phase (word_phase)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference state, built from the requirements
  bit m_symq, m_locked, m_s1, m_sync, m_modeb;
  int m_ph, m_dact, m_hc;
  bit e_valid, e_ph;
  int e_data;
  // monitor state
  bit prev_sym;
  int fall_step = -1, last_ofs = -1, run_len = 0, rises = 0, b_cnt = 0;
  int cur_dly = 0, cur_mode = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp47(input int d);
    return (d > 47) ? 47 : d;
  endfunction

  task automatic step();
    bit fall, lockn, raw, start, b, e_sync;
    int phase, dnow;
    sym_clk  = ((cyc % PERIOD) < PERIOD/2);
    dly_set  = 6'(cur_dly);
    fwd_mode = cur_mode[0];
    adc_word = DW'($urandom);
    fall  = m_symq && !sym_clk;
    phase = fall ? 0 : ((m_ph == PERIOD-1) ? 0 : m_ph + 1);
    dnow  = fall ? clamp47(cur_dly) : m_dact;
    lockn = m_locked || fall;
    raw   = lockn && (phase == dnow);
    start = raw && !(m_s1 || m_sync);
    b     = !start && (m_hc == 1) && m_modeb;
    e_sync  = start || m_s1;
    e_valid = start || b;
    if (e_valid) begin e_data = int'(adc_word); e_ph = b; end
    m_symq = sym_clk; m_ph = phase; m_locked = lockn;
    if (fall) m_dact = clamp47(cur_dly);
    m_hc = start ? PERIOD/2 : ((m_hc != 0) ? m_hc - 1 : 0);
    if (start) m_modeb = cur_mode[0];
    m_s1 = start; m_sync = e_sync;
    @(posedge clk);
    @(negedge clk);
    chk(sync_o == e_sync, "R3", "sync_o", int'(sync_o), int'(e_sync));
    chk(word_valid == e_valid, "R7", "word_valid", int'(word_valid), int'(e_valid));
    if (e_valid) begin
      chk(int'(word_data) == e_data, "R7", "word_data", int'(word_data), e_data);
      chk(word_phase == e_ph, "R8", "word_phase", int'(word_phase), int'(e_ph));
    end
    if (!sym_clk && prev_sym) fall_step = cyc;
    prev_sym = sym_clk;
    if (sync_o) begin
      if (run_len == 0) begin
        rises++;
        last_ofs = (fall_step < 0) ? -1 : cyc - fall_step;
      end
      run_len++;
    end else if (run_len != 0) begin
      chk(run_len == 2, "R4", "pulse width", run_len, 2);
      run_len = 0;
    end
    if (word_valid && word_phase) b_cnt++;
    cyc++;
  endtask

  task automatic run_period(input int d, input int m, input int chg);
    rises = 0; b_cnt = 0;
    for (int i = 0; i < PERIOD; i++) begin
      if (i == chg) begin cur_dly = d; cur_mode = m; end
      step();
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; sym_clk = 1'b1; dly_set = '0; fwd_mode = 1'b0; adc_word = '0;
    m_symq = 0; m_locked = 0; m_s1 = 0; m_sync = 0; m_modeb = 0;
    m_ph = 0; m_dact = 0; m_hc = 0; prev_sym = 0;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk(sync_o == 1'b0, "R1", "sync_o in reset", int'(sync_o), 0);
    chk(word_valid == 1'b0, "R1", "word_valid in reset", int'(word_valid), 0);
    chk(word_data == '0, "R1", "word_data in reset", int'(word_data), 0);
    chk(word_phase == 1'b0, "R1", "word_phase in reset", int'(word_phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync_o == 1'b0 && word_valid == 1'b0, "R1", "after release",
        int'(sync_o) + int'(word_valid), 0);

    // R2: nothing before the first falling edge
    rises = 0; b_cnt = 0;
    for (int i = 0; i < PERIOD/2; i++) step();
    chk(rises == 0, "R2", "pulses before lock", rises, 0);

    run_period(0, 0, 0);
    chk(last_ofs == 0, "R3", "offset d=0", last_ofs, 0);
    run_period(23, 1, 0);
    chk(last_ofs == 23, "R3", "offset d=23", last_ofs, 23);
    chk(b_cnt == 1, "R8", "second words mode 1", b_cnt, 1);
    run_period(63, 0, 0);
    chk(last_ofs == 47, "R5", "offset d=63", last_ofs, 47);
    chk(b_cnt == 0, "R8", "second words mode 0", b_cnt, 0);
    run_period(0, 0, 0);
    chk(rises == 0, "R4", "colliding start dropped", rises, 0);
    run_period(0, 0, 0);
    chk(last_ofs == 0, "R4", "pulse back after drop", last_ofs, 0);

    run_period(10, 0, 0);
    run_period(30, 0, 5);
    chk(last_ofs == 10, "R6", "mid-symbol change ignored", last_ofs, 10);
    run_period(30, 0, 0);
    chk(last_ofs == 30, "R6", "change applied next symbol", last_ofs, 30);

    run_period(40, 1, 0);
    run_period(5, 1, 0);
    chk(b_cnt == 1, "R9", "pending second word cancelled", b_cnt, 1);
    run_period(5, 0, 0);

    for (int p = 0; p < 150; p++)
      run_period(int'($urandom % 64), int'($urandom % 2), int'($urandom % PERIOD));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule